// File: doc/BRIEF.md
# Windowed High Symbol-Error-Rate Monitor

This block watches the per-codeword symbol-error counts coming from a Reed-Solomon decoder. It only acts when the decoder runs in one of the two sub-modes that never mark bad codewords themselves. One of these sub-modes passes data through without correcting it. The other corrects errors but gives no indication when it cannot.

The monitor adds up the reported errors over back-to-back windows of a fixed number of codewords. The windows do not overlap. At the end of each window it compares the total with a threshold. When the total is above the threshold, the monitor raises a high symbol-error-rate flag. It also drives a force-corrupt enable, which tells the downstream framing logic to spoil every 2-bit sync header. This lets the receive path's high bit-error-rate detection take over. The flag is held for a long interval, given in clock cycles by a parameter, and should be sized above 60 ms at the line clock.

Window length, threshold, hold length and error-count width are all parameters. The sub-mode input uses a 2-bit code: 0 means full correction with marking, 1 means marking only, 2 means neither marking nor correction, and 3 means correction without marking.

Top module: `ser_window_monitor`

## Requirements
- R1: Monitoring is active only while `sub_mode` is 2 or 3. For codes 0 and 1, both outputs stay low whatever errors are reported.
- R2: A window is WIN_CW consecutive accepted codewords. A codeword is accepted in a cycle where `cw_valid` is high. In cycles where `cw_valid` is low, `cw_err_cnt` is ignored. The error total starts again from zero with each window, so errors never carry from one window into the next.
- R3: A window trips when its total, including the last codeword, is strictly greater than ERR_LIMIT. A total equal to ERR_LIMIT does not trip. On a trip, `high_ser` rises on the same clock edge that accepts the window's last codeword.
- R4: The error total saturates instead of wrapping. A window whose true total is above the accumulator range still trips.
- R5: After a trip with no later trip, `high_ser` stays high for exactly HOLD_CYC clock cycles and then clears, even if the windows in between carry no errors.
- R6: A window that trips while the hold is running restarts the hold. `high_ser` then stays high for HOLD_CYC cycles counted from that later trip.
- R7: `force_corrupt` is high exactly when `high_ser` is high and monitoring is active. It drops in the same cycle that `sub_mode` leaves codes 2 and 3.
- R8: A cycle with monitoring inactive clears the flag, the hold timer, the error total and the codeword position at the next clock edge. When monitoring resumes, a fresh window starts.
- R9: While `rst_n` is low, and after its release, both outputs are low and the first accepted codeword starts a new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cw_valid | input | 1 | One decoded codeword is reported this cycle |
| cw_err_cnt | input | ERR_W | Symbol errors found in that codeword |
| sub_mode | input | 2 | Decoder sub-mode code (0..3) |
| high_ser | output | 1 | High symbol-error-rate flag |
| force_corrupt | output | 1 | Spoil every sync header downstream |

## Verification
A wrong codeword position or an error total that is not cleared shows up at the ports as a trip that comes one window early or late. It can also show up as a trip built from errors that belong to two windows. Either way it appears no later than one window after the fault. A wrapped accumulator shows up as a missing trip on the first heavily errored window. A timer fault shows up as a flag that is held one or more cycles too long or too short, and this is seen when the hold ends. A missed clear on a sub-mode change shows up at the window end that follows the return to monitoring.

// File: rtl/ser_mon_pkg.sv
// Package: shared sub-mode codes and the monitoring-enable decode.
// Assumes the sub-mode is carried as a 2-bit code, values 0..3.
package ser_mon_pkg;

    typedef enum logic [1:0] {
        SM_CORRECT_MARK = 2'd0,
        SM_MARK_ONLY    = 2'd1,
        SM_RAW_PASS     = 2'd2,
        SM_CORRECT_ONLY = 2'd3
    } sub_mode_e;

    // True for the sub-modes that never mark bad codewords.
    function automatic logic monitor_active(input logic [1:0] mode);
        return (mode == SM_RAW_PASS) || (mode == SM_CORRECT_ONLY);
    endfunction

endpackage

// File: rtl/cw_window_counter.sv
// Counts accepted codewords and flags the one that closes a window.
// Assumes WIN_CW >= 1; clr has priority over counting.
module cw_window_counter #(
    parameter int WIN_CW = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic cw_valid,
    output logic win_last
);

    generate
        if (WIN_CW > 1) begin : g_cnt
            localparam int CNT_W = $clog2(WIN_CW);
            localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WIN_CW - 1);
            logic [CNT_W-1:0] pos_q;

            // Track the position of the next codeword within the window.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    pos_q <= '0;
                end else if (cw_valid) begin
                    pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
                end
            end

            assign win_last = cw_valid && (pos_q == LAST_POS);
        end else begin : g_single
            // Every codeword is a window of its own.
            assign win_last = cw_valid;
        end
    endgenerate

endmodule

// File: rtl/err_accumulator.sv
// Saturating sum of symbol errors over one window.
// Provides the total including the current codeword; restart empties the sum.
module err_accumulator #(
    parameter int ERR_W = 4,
    parameter int ACC_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [ERR_W-1:0] add_val,
    input  logic             restart,
    output logic [ACC_W-1:0] sum_next
);

    localparam int SUM_W = ((ACC_W > ERR_W) ? ACC_W : ERR_W) + 1;
    localparam logic [SUM_W-1:0] SAT_MAX = SUM_W'((64'd1 << ACC_W) - 1);

    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] wide_sum;

    // Widen, add and clamp at the accumulator's top value.
    always_comb begin
        wide_sum = SUM_W'(acc_q) + (add_en ? SUM_W'(add_val) : '0);
        sum_next = (wide_sum > SAT_MAX) ? '1 : wide_sum[ACC_W-1:0];
    end

    // Hold the running total; empty it on window close or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (restart) begin
            acc_q <= '0;
        end else if (add_en) begin
            acc_q <= sum_next;
        end
    end

endmodule

// File: rtl/hold_timer.sv
// Keeps 'active' high for HOLD_CYC cycles after the last load.
// Assumes HOLD_CYC >= 1; load restarts a running hold; clr wins over load.
module hold_timer #(
    parameter int HOLD_CYC = 20_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    output logic active
);

    localparam int TMR_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [TMR_W-1:0] RELOAD = TMR_W'(HOLD_CYC - 1);

    logic [TMR_W-1:0] left_q;
    logic             act_q;

    // Load, count down, and drop the flag when the count is spent.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            left_q <= '0;
            act_q  <= 1'b0;
        end else if (load) begin
            left_q <= RELOAD;
            act_q  <= 1'b1;
        end else if (act_q) begin
            if (left_q == '0) begin
                act_q <= 1'b0;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign active = act_q;

endmodule

// File: rtl/ser_window_monitor.sv
// Top: windowed symbol-error monitor for the non-marking decoder sub-modes.
// Assumes one cw_valid strobe per decoded codeword and a stable sub_mode
// between changes; any cycle outside monitoring sub-modes clears all state.
module ser_window_monitor
    import ser_mon_pkg::*;
#(
    parameter int WIN_CW    = 8192,
    parameter int ERR_LIMIT = 417,
    parameter int HOLD_CYC  = 20_000_000,
    parameter int ERR_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cw_valid,
    input  logic [ERR_W-1:0] cw_err_cnt,
    input  logic [1:0]       sub_mode,
    output logic             high_ser,
    output logic             force_corrupt
);

    localparam int ACC_W = $clog2(ERR_LIMIT + 2);
    localparam logic [ACC_W-1:0] LIMIT_V = ACC_W'(ERR_LIMIT);

    logic             mon_en;
    logic             cw_take;
    logic             win_last;
    logic [ACC_W-1:0] win_sum;
    logic             win_trip;
    logic             hold_on;

    // Decode whether this sub-mode needs monitoring.
    always_comb begin
        mon_en  = monitor_active(sub_mode);
        cw_take = mon_en && cw_valid;
    end

    cw_window_counter #(
        .WIN_CW (WIN_CW)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!mon_en),
        .cw_valid (cw_take),
        .win_last (win_last)
    );

    err_accumulator #(
        .ERR_W (ERR_W),
        .ACC_W (ACC_W)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!mon_en),
        .add_en   (cw_take),
        .add_val  (cw_err_cnt),
        .restart  (win_last),
        .sum_next (win_sum)
    );

    // Compare the closing window's total with the threshold.
    always_comb begin
        win_trip = win_last && (win_sum > LIMIT_V);
    end

    hold_timer #(
        .HOLD_CYC (HOLD_CYC)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!mon_en),
        .load   (win_trip),
        .active (hold_on)
    );

    // Drive the flag and gate the corruption enable with the sub-mode.
    always_comb begin
        high_ser      = hold_on;
        force_corrupt = hold_on && mon_en;
    end

endmodule

// File: rtl/ser_window_monitor_chk.sv
// Checker for ser_window_monitor, attached with bind below.
// Keeps its own codeword and hold counters, so long windows need no deep $past.
module ser_window_monitor_chk
    import ser_mon_pkg::*;
#(
    parameter int WIN_CW   = 8192,
    parameter int HOLD_CYC = 20_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cw_valid,
    input logic [1:0] sub_mode,
    input logic       high_ser,
    input logic       force_corrupt,
    input logic       trip
);

    logic en;
    int   vcnt;
    int   hcnt;

    assign en = monitor_active(sub_mode);

    // Independent position of the next codeword within its window.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            vcnt <= 0;
        end else if (cw_valid) begin
            vcnt <= (vcnt == WIN_CW - 1) ? 0 : vcnt + 1;
        end
    end

    // Cycles the flag has been high since the latest trip.
    always_ff @(posedge clk) begin
        if (!rst_n || trip || !high_ser) begin
            hcnt <= 0;
        end else begin
            hcnt <= hcnt + 1;
        end
    end

    p_off_mode_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !force_corrupt);

    p_trip_at_window_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> (cw_valid && vcnt == WIN_CW - 1));

    p_rise_follows_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(high_ser) |-> $past(trip));

    p_hold_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        high_ser |-> (hcnt < HOLD_CYC));

    p_retrigger_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> high_ser);

    p_force_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        force_corrupt |-> high_ser);

    p_off_mode_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !high_ser);

endmodule

bind ser_window_monitor ser_window_monitor_chk #(
    .WIN_CW   (WIN_CW),
    .HOLD_CYC (HOLD_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cw_valid      (cw_valid),
    .sub_mode      (sub_mode),
    .high_ser      (high_ser),
    .force_corrupt (force_corrupt),
    .trip          (win_trip)
);

// File: tb/test_ser_window_monitor.sv
module test_ser_window_monitor;

    localparam int WIN  = 4;
    localparam int LIM  = 5;
    localparam int HOLD = 12;
    localparam int EW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cw_valid = 1'b0;
    logic [EW-1:0] cw_err_cnt = '0;
    logic [1:0]    sub_mode = 2'd2;
    logic          high_ser;
    logic          force_corrupt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference state, derived from the requirements.
    int m_pos = 0, m_sum = 0, m_left = 0;
    bit m_flag = 1'b0;

    always #4 clk = ~clk;

    ser_window_monitor #(
        .WIN_CW (WIN), .ERR_LIMIT (LIM), .HOLD_CYC (HOLD), .ERR_W (EW)
    ) i_ser_window_monitor (
        .clk (clk), .rst_n (rst_n), .cw_valid (cw_valid),
        .cw_err_cnt (cw_err_cnt), .sub_mode (sub_mode),
        .high_ser (high_ser), .force_corrupt (force_corrupt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // One clock of the reference: true (unbounded) sum, strict compare.
    task automatic model(input bit v, input int e, input int m);
        bit trip = 1'b0;
        if (m < 2) begin
            m_pos = 0; m_sum = 0; m_left = 0; m_flag = 1'b0;
        end else begin
            if (v) begin
                if (m_pos == WIN - 1) begin
                    trip = (m_sum + e) > LIM;
                    m_sum = 0; m_pos = 0;
                end else begin
                    m_sum += e; m_pos++;
                end
            end
            if (trip) begin
                m_flag = 1'b1; m_left = HOLD - 1;
            end else if (m_flag) begin
                if (m_left == 0) m_flag = 1'b0;
                else m_left--;
            end
        end
    endtask

    task automatic step(input bit v, input int e, input int m, input string req);
        cw_valid = v; cw_err_cnt = EW'(e); sub_mode = 2'(m);
        @(posedge clk);
        model(v, e, m);
        @(negedge clk);
        check(req, "high_ser", int'(high_ser), int'(m_flag));
        check(req, "force_corrupt", int'(force_corrupt), int'(m_flag && m >= 2));
    endtask

    task automatic idle(input int n, input int m, input string req);
        for (int i = 0; i < n; i++) step(1'b0, 15, m, req);
    endtask

    task automatic window(input int total, input int m, input string req);
        for (int i = 0; i < WIN; i++)
            step(1'b1, total / WIN + ((i < total % WIN) ? 1 : 0), m, req);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; cw_valid = 1'b0;
        repeat (3) @(posedge clk);
        m_pos = 0; m_sum = 0; m_left = 0; m_flag = 1'b0;
        @(negedge clk);
        check("R9", "high_ser in reset", int'(high_ser), 0);
        check("R9", "force_corrupt in reset", int'(force_corrupt), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: run did not complete (expected completion)");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int cnt;
        @(negedge clk);
        do_reset();

        // R1: non-monitoring sub-modes ignore heavy errors.
        for (int m = 0; m < 2; m++)
            for (int w = 0; w < 3; w++) window(60, m, "R1");

        // R3: threshold sweep in both monitoring sub-modes.
        for (int m = 2; m < 4; m++)
            for (int t = 0; t <= 2 * LIM; t++) begin
                window(t, m, "R3");
                idle(HOLD + 2, m, "R3");
            end

        // R2: errors straddling a boundary, with ignored gap cycles.
        for (int a = 0; a <= LIM; a++)
            for (int b = 0; b <= LIM; b++) begin
                step(1'b1, 0, 3, "R2"); idle(1, 3, "R2");
                step(1'b1, 0, 3, "R2"); step(1'b1, 0, 3, "R2");
                step(1'b1, a, 3, "R2"); idle(2, 3, "R2");
                step(1'b1, b, 3, "R2"); step(1'b1, 0, 3, "R2");
                step(1'b1, 0, 3, "R2"); step(1'b1, 0, 3, "R2");
            end

        // R4: totals far past the accumulator range.
        step(1'b1, 4, 2, "R4"); step(1'b1, 4, 2, "R4");
        step(1'b1, 0, 2, "R4"); step(1'b1, 0, 2, "R4");
        idle(HOLD + 2, 2, "R4");
        window(60, 2, "R4");
        idle(HOLD + 2, 2, "R4");

        // R5: exact hold length over clean windows.
        window(LIM + 1, 3, "R5");
        cnt = 1;
        for (int i = 0; i < 3 * HOLD; i++) begin
            step(1'b1, 0, 3, "R5");
            if (high_ser) cnt++;
        end
        check("R5", "hold length", cnt, HOLD);

        // R6: second trip during hold restarts it.
        window(LIM + 1, 3, "R6");
        idle(5, 3, "R6");
        window(LIM + 1, 3, "R6");
        cnt = 1;
        for (int i = 0; i < 3 * HOLD; i++) begin
            step(1'b0, 0, 3, "R6");
            if (high_ser) cnt++;
        end
        check("R6", "restarted hold length", cnt, HOLD);

        // R7: force drops in the very cycle the sub-mode leaves.
        window(LIM + 1, 2, "R7");
        sub_mode = 2'd1;
        #1;
        check("R7", "force_corrupt same cycle", int'(force_corrupt), 0);
        check("R7", "high_ser still held", int'(high_ser), 1);
        step(1'b0, 0, 1, "R8");
        check("R8", "flag cleared", int'(high_ser), 0);

        // R8: partial window discarded across a sub-mode change.
        step(1'b1, 3, 3, "R8"); step(1'b1, 3, 3, "R8");
        step(1'b0, 0, 0, "R8");
        step(1'b1, 3, 3, "R8"); step(1'b1, 0, 3, "R8");
        step(1'b1, 0, 3, "R8"); step(1'b1, 0, 3, "R8");
        check("R8", "no trip from stale errors", int'(high_ser), 0);

        // R9: reset mid-hold, then a fresh window.
        window(LIM + 1, 3, "R9");
        idle(2, 3, "R9");
        do_reset();
        idle(3, 3, "R9");
        window(LIM, 3, "R9");
        window(LIM + 1, 3, "R9");
        idle(HOLD + 2, 3, "R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule